// File: doc/BRIEF.md
# Lane Scrambler with Periodic Reset-Symbol Insertion

This block sits in one transmit lane between the link layer and an 8b/10b encoder. Every accepted beat carries two 8-bit symbols, each with its own control flag. Data symbols are XORed with a keystream from a 16-bit LFSR. The LFSR is unrolled so that it produces the keystream for both symbol slots in a single cycle. Control symbols pass through unscrambled, but they still consume keystream. The block counts blank-start control symbols. When insertion is enabled, it swaps a periodic one of them for a scrambler-reset control symbol. Any scrambler-reset symbol that leaves the block re-seeds the LFSR, so the receiving end can resynchronise.

The scrambled beat then goes through a short register chain. The chain adds a skew of two cycles per lane index, so that adjacent lanes leave the transmitter offset in time. The skew can be bypassed. Input and output are valid/ready streams, and the whole lane advances as one unit. `in_ready` follows `out_ready`. When `out_ready` is low, every register holds, including the LFSR, the counter and the skew chain. This is true even when `out_valid` is low. A beat is accepted on an edge where both `in_valid` and `in_ready` are high. A cycle that advances without an input beat pushes an empty (invalid, all-zero) slot into the pipeline.

Top module: `lscr_lane`

## Requirements
- R1: A synchronous reset (`rst` high on an edge) loads LFSR state 16'hFFFF and clears the blank-start counter. It also empties the pipeline, so that `out_valid`, `out_data` and `out_ctl` read 0 afterwards.
- R2: The LFSR is 16 bits wide. For each keystream bit, the output is state bit 15. The state then shifts left with a 0 entering bit 0, and it is XORed with 16'h0039 if the output bit was 1. The first output of a group of eight becomes bit 0 of the key byte. Slot 0 (`[7:0]`, flag bit 0) uses the first eight steps and slot 1 (`[15:8]`, flag bit 1) the next eight. A data symbol (flag 0) leaves as the byte XOR the key.
- R3: A control symbol (flag 1) leaves with its byte and flag unchanged, and the LFSR still takes its eight steps.
- R4: With `sr_en` high, blank-start symbols (flag 1, byte 8'hBC) are counted. Every 512th one since reset or since the last insertion leaves as a scrambler-reset symbol (flag 1, byte 8'h1C).
- R5: After any symbol that leaves as flag 1 with byte 8'h1C, the LFSR is reloaded with 16'hFFFF, so the next symbol position uses the seed keystream.
- R6: With `sr_en` low, blank-start symbols pass unchanged and the counter holds its value.
- R7: Two blank-start symbols in one beat are counted one after the other, in slot order. An insertion in slot 0 re-seeds the LFSR before slot 1 is scrambled.
- R8: With `skew_en` low, a beat accepted on an edge is at the outputs in the cycle after that edge. With `skew_en` high it appears 2×`lane_idx` cycles later. Flags travel with their bytes.
- R9: While `out_ready` is low, `in_ready` is low, and a valid output keeps its data and flags. The LFSR and the counter do not change.
- R10: Cycles without an accepted beat neither advance the LFSR nor touch the counter. They produce no valid output beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Lane can accept a beat (follows out_ready) |
| in_data | input | 16 | Two symbols, slot 0 in [7:0], slot 1 in [15:8] |
| in_ctl | input | 2 | Control flag per slot |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts; low stalls the lane |
| out_data | output | 16 | Scrambled symbols toward the encoder |
| out_ctl | output | 2 | Control flags travelling with out_data |
| sr_en | input | 1 | Enable reset-symbol insertion |
| skew_en | input | 1 | Enable the per-lane skew delay |
| lane_idx | input | 2 | Lane index selecting 0, 2, 4 or 6 cycles of skew |

## Verification
The hold property assumes that `lane_idx` and `skew_en` stay fixed while `out_ready` is low. It also assumes that they change only when the skew chain holds no beats, because switching taps mid-flight legitimately drops or repeats beats. The bench therefore changes them only after a run of empty cycles has flushed the chain, and it never changes them during a stall. `sr_en` is changed only between beats, after a reset. The checks on flags and on blank-start sources look one cycle back and are guarded so that they apply only after a cycle in which the lane advanced.

// File: rtl/lscr_pkg.sv
`timescale 1ns/1ps
package lscr_pkg;
  localparam int SYM_W = 8;
  localparam int LFSR_W = 16;
  localparam logic [SYM_W-1:0] BS_CODE = 8'hBC;
  localparam logic [SYM_W-1:0] SR_CODE = 8'h1C;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hFFFF;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'h0039;

  // Eight serial LFSR steps in one go: returns {key byte, next state}.
  function automatic logic [SYM_W+LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] st);
    logic [LFSR_W-1:0] r;
    logic [SYM_W-1:0] key;
    logic fb;
    r = st;
    key = '0;
    for (int i = 0; i < SYM_W; i++) begin
      fb = r[LFSR_W-1];
      key[i] = fb;
      r = {r[LFSR_W-2:0], 1'b0} ^ (fb ? LFSR_TAPS : '0);
    end
    return {key, r};
  endfunction
endpackage

// File: rtl/lscr_scramble.sv
`timescale 1ns/1ps
module lscr_scramble
  import lscr_pkg::*;
#(
  parameter int SLOTS = 2,
  parameter int SR_PERIOD = 512
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   adv,
  input  logic                   in_valid,
  input  logic [SLOTS*SYM_W-1:0] in_data,
  input  logic [SLOTS-1:0]       in_ctl,
  input  logic                   sr_en,
  output logic                   o_valid,
  output logic [SLOTS*SYM_W-1:0] o_data,
  output logic [SLOTS-1:0]       o_ctl
);
  localparam int DW = SLOTS * SYM_W;
  localparam int CNT_W = $clog2(SR_PERIOD);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SR_PERIOD - 1);

  logic [LFSR_W-1:0] lfsr_q, lfsr_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DW-1:0]     dat_n;

  logic [SYM_W-1:0]        sym, outb;
  logic [SYM_W+LFSR_W-1:0] step;
  logic                    is_bs, ins;

  // Slot chain: each slot sees counter and LFSR as left by the slot before.
  always_comb begin
    lfsr_n = lfsr_q;
    cnt_n  = cnt_q;
    dat_n  = '0;
    sym = '0; outb = '0; step = '0; is_bs = 1'b0; ins = 1'b0;
    for (int j = 0; j < SLOTS; j++) begin
      sym   = in_data[j*SYM_W +: SYM_W];
      is_bs = in_ctl[j] && (sym == BS_CODE);
      ins   = sr_en && is_bs && (cnt_n == CNT_LAST);
      if (sr_en && is_bs)
        cnt_n = ins ? '0 : cnt_n + 1'b1;
      step = lfsr_advance(lfsr_n);
      if (ins)            outb = SR_CODE;
      else if (in_ctl[j]) outb = sym;
      else                outb = sym ^ step[LFSR_W +: SYM_W];
      dat_n[j*SYM_W +: SYM_W] = outb;
      lfsr_n = (in_ctl[j] && outb == SR_CODE) ? LFSR_SEED : step[LFSR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q  <= LFSR_SEED;
      cnt_q   <= '0;
      o_valid <= 1'b0;
      o_data  <= '0;
      o_ctl   <= '0;
    end else if (adv) begin
      o_valid <= in_valid;
      if (in_valid) begin
        lfsr_q <= lfsr_n;
        cnt_q  <= cnt_n;
        o_data <= dat_n;
        o_ctl  <= in_ctl;
      end else begin
        o_data <= '0;
        o_ctl  <= '0;
      end
    end
  end
endmodule

// File: rtl/lscr_skew.sv
`timescale 1ns/1ps
module lscr_skew #(
  parameter int W = 18,
  parameter int DEPTH = 6,
  parameter int STEP = 2,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             en,
  input  logic [SEL_W-1:0] lane,
  input  logic             in_valid,
  input  logic [W-1:0]     in_pay,
  output logic             out_valid,
  output logic [W-1:0]     out_pay
);
  logic [DEPTH:1] v_q;
  logic [W-1:0]   p_q [1:DEPTH];
  logic           tap_v [0:DEPTH];
  logic [W-1:0]   tap_p [0:DEPTH];
  int             sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      for (int g = 1; g <= DEPTH; g++) p_q[g] <= '0;
    end else if (adv) begin
      v_q[1] <= in_valid;
      p_q[1] <= in_pay;
      for (int g = 2; g <= DEPTH; g++) begin
        v_q[g] <= v_q[g-1];
        p_q[g] <= p_q[g-1];
      end
    end
  end

  always_comb begin
    tap_v[0] = in_valid;
    tap_p[0] = in_pay;
    for (int g = 1; g <= DEPTH; g++) begin
      tap_v[g] = v_q[g];
      tap_p[g] = p_q[g];
    end
    sel = en ? int'(lane) * STEP : 0;
    if (sel > DEPTH) sel = DEPTH;
    out_valid = tap_v[sel];
    out_pay   = tap_p[sel];
  end
endmodule

// File: rtl/lscr_lane.sv
`timescale 1ns/1ps
module lscr_lane
  import lscr_pkg::*;
#(
  parameter int SLOTS = 2,
  parameter int SR_PERIOD = 512,
  parameter int LANE_W = 2,
  parameter int LANE_STEP = 2,
  parameter int SKEW_DEPTH = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [SLOTS*SYM_W-1:0] in_data,
  input  logic [SLOTS-1:0]       in_ctl,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [SLOTS*SYM_W-1:0] out_data,
  output logic [SLOTS-1:0]       out_ctl,
  input  logic                   sr_en,
  input  logic                   skew_en,
  input  logic [LANE_W-1:0]      lane_idx
);
  localparam int DW = SLOTS * SYM_W;
  localparam int PW = DW + SLOTS;

  logic          c_valid;
  logic [DW-1:0] c_dat;
  logic [SLOTS-1:0] c_ctl;

  assign in_ready = out_ready;

  lscr_scramble #(.SLOTS(SLOTS), .SR_PERIOD(SR_PERIOD)) u_scr (
    .clk(clk), .rst(rst), .adv(out_ready),
    .in_valid(in_valid), .in_data(in_data), .in_ctl(in_ctl), .sr_en(sr_en),
    .o_valid(c_valid), .o_data(c_dat), .o_ctl(c_ctl)
  );

  lscr_skew #(.W(PW), .DEPTH(SKEW_DEPTH), .STEP(LANE_STEP), .SEL_W(LANE_W)) u_skw (
    .clk(clk), .rst(rst), .adv(out_ready), .en(skew_en), .lane(lane_idx),
    .in_valid(c_valid), .in_pay({c_ctl, c_dat}),
    .out_valid(out_valid), .out_pay({out_ctl, out_data})
  );
endmodule

// File: rtl/lscr_lane_chk.sv
`timescale 1ns/1ps
module lscr_lane_chk
  import lscr_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [SLOTS*SYM_W-1:0] in_data,
  input logic [SLOTS-1:0]       in_ctl,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [SLOTS*SYM_W-1:0] out_data,
  input logic [SLOTS-1:0]       out_ctl,
  input logic                   sr_en,
  input logic                   c_valid,
  input logic [SLOTS*SYM_W-1:0] c_dat,
  input logic [SLOTS-1:0]       c_ctl
);
  p_rst_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_data == '0 && out_ctl == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctl)));

  p_ctl_pass_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && in_valid && out_ready) |-> (c_valid && c_ctl == $past(in_ctl)));

  p_bubble_r10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !in_valid && out_ready) |-> !c_valid);

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    p_sr_src_r4: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst && out_ready) && c_valid && c_ctl[j] && c_dat[j*SYM_W +: SYM_W] == SR_CODE)
      |-> $past(in_ctl[j] && (in_data[j*SYM_W +: SYM_W] == BS_CODE ||
                              in_data[j*SYM_W +: SYM_W] == SR_CODE)));

    p_nosr_r6: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && out_ready && in_valid && !sr_en && in_ctl[j])
      |-> (c_dat[j*SYM_W +: SYM_W] == $past(in_data[j*SYM_W +: SYM_W])));
  end
endmodule

bind lscr_lane lscr_lane_chk #(.SLOTS(SLOTS)) u_chk (.*);

// File: tb/lscr_lane_test.sv
`timescale 1ns/1ps
module lscr_lane_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1, sr_en = 1'b0, skew_en = 1'b0;
  logic [15:0] in_data = '0;
  logic [1:0]  in_ctl = '0, lane_idx = '0;
  logic        in_ready, out_valid;
  logic [15:0] out_data;
  logic [1:0]  out_ctl;

  int total = 0, bad = 0, sr_seen = 0, n_valid = 0;
  string cur_req = "R1";
  logic [17:0] expq [$];
  logic [17:0] last_out = '0;
  logic [15:0] m_s = 16'hFFFF;
  int          m_c = 0;

  always #5 clk = ~clk;

  lscr_lane uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ctl(in_ctl), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ctl(out_ctl), .sr_en(sr_en), .skew_en(skew_en),
    .lane_idx(lane_idx)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Reference keystream per the R2 definition: {key byte, next state}.
  function automatic logic [23:0] ref_key(input logic [15:0] s);
    logic [7:0] k;
    logic b;
    for (int i = 0; i < 8; i++) begin
      b = s[15];
      k[i] = b;
      s = s << 1;
      if (b) s = s ^ 16'h0039;
    end
    return {k, s};
  endfunction

  task automatic mdl_beat(input logic [15:0] d, input logic [1:0] k);
    logic [15:0] od;
    logic [23:0] r;
    logic [7:0]  b, o;
    logic        bs, ins;
    for (int j = 0; j < 2; j++) begin
      b   = d[j*8 +: 8];
      bs  = k[j] && b == 8'hBC;
      ins = sr_en && bs && m_c == 511;
      if (sr_en && bs) m_c = ins ? 0 : m_c + 1;
      r = ref_key(m_s);
      o = ins ? 8'h1C : (k[j] ? b : b ^ r[23:16]);
      od[j*8 +: 8] = o;
      m_s = (k[j] && o == 8'h1C) ? 16'hFFFF : r[15:0];
    end
    expq.push_back({k, od});
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      n_valid++;
      last_out = {out_ctl, out_data};
      for (int j = 0; j < 2; j++)
        if (out_ctl[j] && out_data[j*8 +: 8] == 8'h1C) sr_seen++;
      if (expq.size() == 0) begin
        chk(1'b0, cur_req, "unexpected output beat", {out_ctl, out_data}, 0);
      end else begin
        logic [17:0] e;
        e = expq.pop_front();
        chk({out_ctl, out_data} == e, cur_req, "output beat", {out_ctl, out_data}, e);
      end
    end
  end

  task automatic send(input logic [15:0] d, input logic [1:0] k);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = d; in_ctl = k;
    mdl_beat(d, k);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0; in_data = '0; in_ctl = '0;
    end
  endtask

  task automatic drain(input string req);
    idle(10);
    chk(expq.size() == 0, req, "pending expected beats", expq.size(), 0);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; in_valid = 1'b1; in_data = 16'h5A5A; in_ctl = 2'b01;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0; in_valid = 1'b0; in_data = '0; in_ctl = '0;
    m_s = 16'hFFFF; m_c = 0;
    expq.delete();
  endtask

  task automatic t_reset();
    logic [23:0] r0, r1;
    cur_req = "R1";
    do_reset();
    @(negedge clk);
    chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    chk(out_data == 0, "R1", "out_data after reset", out_data, 0);
    chk(out_ctl == 0, "R1", "out_ctl after reset", out_ctl, 0);
    send(16'h1234, 2'b00); send(16'h0F0F, 2'b00); send(16'hFFFF, 2'b00);
    drain("R1");
    do_reset();
    send(16'h0000, 2'b00);
    drain("R1");
    r0 = ref_key(16'hFFFF); r1 = ref_key(r0[15:0]);
    chk(last_out == {2'b00, r1[23:16], r0[23:16]}, "R1", "seed keystream after mid-run reset",
        last_out, {2'b00, r1[23:16], r0[23:16]});
  endtask

  task automatic t_scramble();
    cur_req = "R2";
    do_reset();
    send(16'h0000, 2'b00); send(16'hFFFF, 2'b00); send(16'hA55A, 2'b00);
    for (int i = 0; i < 13; i++) send(16'(i * 16'h0307 + 16'h0102), 2'b00);
    drain("R2");
  endtask

  task automatic t_control();
    cur_req = "R3";
    do_reset();
    send(16'h00FB, 2'b01); send(16'h7C00, 2'b10); send(16'hFD7C, 2'b11);
    send(16'h1111, 2'b00); send(16'h22BC, 2'b01); send(16'h3344, 2'b00);
    drain("R3");
  endtask

  task automatic t_sr();
    logic [23:0] r0;
    int base;
    cur_req = "R4";
    do_reset();
    sr_en = 1'b1;
    base = sr_seen;
    send(16'h11BC, 2'b01);
    for (int i = 0; i < 255; i++) send(16'hBCBC, 2'b11);
    send(16'h00BC, 2'b01);
    drain("R4");
    r0 = ref_key(16'hFFFF);
    chk(sr_seen - base == 1, "R4", "reset symbols after 512 blank starts", sr_seen - base, 1);
    chk(last_out[7:0] == 8'h1C && last_out[16], "R4", "slot0 replaced", last_out[7:0], 8'h1C);
    chk(last_out[15:8] == r0[23:16], "R5", "slot1 uses seed key", last_out[15:8], r0[23:16]);
    for (int i = 0; i < 256; i++) send(16'hBCBC, 2'b11);
    drain("R4");
    chk(sr_seen - base == 2, "R4", "second period insertion", sr_seen - base, 2);
    chk(last_out == {2'b11, 16'h1CBC}, "R4", "512th of second period in slot1", last_out, {2'b11, 16'h1CBC});
  endtask

  task automatic t_double();
    logic [23:0] r0, r1;
    cur_req = "R7";
    do_reset();
    sr_en = 1'b1;
    for (int i = 0; i < 255; i++) send(16'hBCBC, 2'b11);
    send(16'hBCBC, 2'b11);
    drain("R7");
    chk(last_out == {2'b11, 16'h1CBC}, "R7", "511th passes, 512th replaced", last_out, {2'b11, 16'h1CBC});
    send(16'h0000, 2'b00);
    drain("R5");
    r0 = ref_key(16'hFFFF); r1 = ref_key(r0[15:0]);
    chk(last_out == {2'b00, r1[23:16], r0[23:16]}, "R5", "reseed after slot1 reset symbol",
        last_out, {2'b00, r1[23:16], r0[23:16]});
  endtask

  task automatic t_disabled();
    int base;
    cur_req = "R6";
    do_reset();
    sr_en = 1'b0;
    base = sr_seen;
    for (int i = 0; i < 300; i++) send(16'hBCBC, 2'b11);
    send(16'h4321, 2'b00);
    drain("R6");
    chk(sr_seen == base, "R6", "no insertion while disabled", sr_seen - base, 0);
    sr_en = 1'b1;
    for (int i = 0; i < 255; i++) send(16'hBCBC, 2'b11);
    drain("R6");
    chk(sr_seen == base, "R6", "counter held while disabled", sr_seen - base, 0);
    sr_en = 1'b0;
  endtask

  task automatic measure(input int exp_c, input string what);
    int c;
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = 16'hC3A5; in_ctl = 2'b10;
    mdl_beat(16'hC3A5, 2'b10);
    @(posedge clk); #1;
    in_valid = 1'b0; in_data = '0; in_ctl = '0;
    c = 0;
    while (c < 20) begin
      @(negedge clk);
      if (out_valid) break;
      c++;
    end
    chk(c == exp_c, "R8", what, c, exp_c);
    drain("R8");
  endtask

  task automatic t_skew();
    cur_req = "R8";
    do_reset();
    skew_en = 1'b1;
    for (int l = 0; l < 4; l++) begin
      lane_idx = 2'(l);
      idle(8);
      measure(2 * l, "skew latency");
    end
    skew_en = 1'b0;
    idle(8);
    measure(0, "bypass latency with lane 3");
    lane_idx = '0;
    idle(8);
  endtask

  task automatic t_backpressure();
    logic [17:0] cap;
    cur_req = "R9";
    do_reset();
    send(16'h6789, 2'b00);
    @(posedge clk); #1;
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 16'hBEEF; in_ctl = 2'b00;
    @(negedge clk);
    cap = {out_ctl, out_data};
    chk(out_valid, "R9", "beat present before stall", out_valid, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk({out_ctl, out_data} == cap && out_valid, "R9", "held during stall", {out_ctl, out_data}, cap);
      chk(!in_ready, "R9", "in_ready low during stall", in_ready, 0);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    mdl_beat(16'hBEEF, 2'b00);
    send(16'h0000, 2'b00);
    drain("R9");
  endtask

  task automatic t_bubble();
    int base;
    cur_req = "R10";
    do_reset();
    sr_en = 1'b1;
    base = n_valid;
    send(16'h0102, 2'b00);
    idle(3);
    send(16'h03BC, 2'b01);
    idle(2);
    send(16'h0405, 2'b00);
    drain("R10");
    chk(n_valid - base == 3, "R10", "valid beats out", n_valid - base, 3);
    sr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_scramble();
    t_control();
    t_sr();
    t_double();
    t_disabled();
    t_skew();
    t_backpressure();
    t_bubble();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule